// File: doc/BRIEF.md
# Dual-Mode Control Word Loader

This block collects a 40-bit programming word for a numerically controlled oscillator and hands it over on command. Words arrive one write strobe at a time, either as five bytes on an 8-bit bus or as a stream of 40 single bits taken from the bus's top bit. A rising edge on the update input copies the collected word into an active register set. That register set drives a 32-bit tuning word, a 5-bit phase word and a power-down bit.

In byte mode a pointer chooses which byte of the holding register each write fills. The pointer stops after the fifth byte, and both an update edge and a master reset send it back to the first byte. The loader comes out of power-on reset in byte mode. It switches to bit-stream mode only when a first byte carrying control code 11 is committed. Control codes reserved for factory test never reach the active registers; when one is offered, a sticky error flag is set instead. The master reset clears the active registers and the error flag. It leaves the holding register and the mode as they are.

Top module: `cwl_loader`

## Requirements
- R1: After power-on reset (rst_n low), tune_o, phase_o, pdown_o, serial_o and err_o are all zero and the loader is in byte mode.
- R2: In byte mode the writes fill bytes in the order first, second, third, fourth, fifth. The first byte holds the phase word in bus[7:3] (bit 7 is the MSB), the power-down bit in bus[2] and the control code in bus[1:0]. The second to fifth bytes hold tuning bits 31..24, 23..16, 15..8 and 7..0. An update edge sampled at clock edge k shows the new values on the outputs after edge k.
- R3: Once five bytes have been written, further writes in byte mode leave the holding register unchanged.
- R4: An update after fewer than five writes commits the holding register as it stands. Bytes that were not rewritten keep their earlier contents.
- R5: An update edge returns the pointer to the first byte, so the next write fills the first byte again.
- R6: Committing a first byte with control code 11 while in byte mode switches the loader to bit-stream mode (serial_o = 1) and leaves the active registers unchanged. Only rst_n returns the loader to byte mode.
- R7: In bit-stream mode each write shifts in bus[7], and the remaining bus bits are ignored. Of the last 40 bits, the first 32 are tuning bits 0 to 31 in order, then control bits 0 and 1, then the power-down bit, then phase bits 0 to 4.
- R8: Some control codes are reserved. In byte mode these are 01 and 10; in bit-stream mode any code other than 00 is reserved. Committing a reserved code leaves the active registers unchanged and sets err_o. err_o stays set until a reset.
- R9: Master reset (mrst_i) clears tune_o, phase_o, pdown_o and err_o, and returns the pointer to the first byte. It leaves the holding register and the mode unchanged.
- R10: Only a rising edge of upd_i commits. Holding upd_i high while writing does not commit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_i | input | 1 | Master reset, synchronous, active high |
| wr_i | input | 1 | Write strobe, one load per cycle high |
| upd_i | input | 1 | Update level; its rising edge commits |
| bus_i | input | 8 | Byte data; bit 7 also carries serial data |
| tune_o | output | 32 | Active tuning word |
| phase_o | output | 5 | Active phase word |
| pdown_o | output | 1 | Active power-down bit |
| serial_o | output | 1 | 1 when in bit-stream mode |
| err_o | output | 1 | Sticky flag: a reserved code was offered |

## Verification
The bench runs a sixth and seventh write after a full load. A pointer that wrapped around instead of stopping would overwrite the phase byte, and the commit that follows would show it. It commits partial loads and reloads the first byte after an update, which exposes a pointer that is not rewound or a holding register that is cleared on commit. It offers each reserved code in both modes, so a design that lets a test code through would change the outputs or fail to raise the flag. It sends a 40-bit stream with junk on the lower bus bits, which catches a reversed shift direction or a wrong source bit. Finally it checks, after a master reset, that the committed word is the one collected before the reset and that bit-stream mode is still active.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  localparam int TUNE_W  = 32;
  localparam int PHASE_W = 5;
  localparam int CTL_LSB = 32;
  localparam int PD_BIT  = 34;
  localparam int PH_LSB  = 35;

  typedef enum logic [1:0] {
    CTL_NORMAL = 2'b00,
    CTL_TEST_A = 2'b01,
    CTL_TEST_B = 2'b10,
    CTL_SERIAL = 2'b11
  } ctl_e;

  typedef enum logic {
    MODE_BYTE = 1'b0,
    MODE_BIT  = 1'b1
  } mode_e;

  typedef struct packed {
    logic [PHASE_W-1:0] phase;
    logic               pd;
    logic [TUNE_W-1:0]  tune;
  } act_t;

  function automatic act_t unpack_word(input logic [PH_LSB+PHASE_W-1:0] w);
    act_t a;
    a.phase = w[PH_LSB +: PHASE_W];
    a.pd    = w[PD_BIT];
    a.tune  = w[TUNE_W-1:0];
    return a;
  endfunction
endpackage

// File: rtl/cwl_rst_sync.sv
module cwl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/cwl_assembler.sv
module cwl_assembler #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_i,
  input  logic                     upd_edge_i,
  input  logic                     mrst_i,
  input  logic                     serial_i,
  input  logic [BYTE_W-1:0]        bus_i,
  output logic [NBYTES*BYTE_W-1:0] hold_o
);
  localparam int WORD_W = NBYTES * BYTE_W;
  localparam int PTR_W  = $clog2(NBYTES + 1);
  localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(NBYTES);

  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [WORD_W-1:0] hold_q, hold_d, par_word;
  logic              hold_en;

  // byte lanes: the first byte sits at the top of the holding word
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    localparam int HI = WORD_W - 1 - g * BYTE_W;
    assign par_word[HI -: BYTE_W] = (ptr_q == PTR_W'(g)) ? bus_i : hold_q[HI -: BYTE_W];
  end

  always_comb begin
    ptr_d   = ptr_q;
    hold_d  = hold_q;
    hold_en = 1'b0;
    if (mrst_i || upd_edge_i) begin
      ptr_d = '0;
    end else if (wr_i) begin
      if (serial_i) begin
        hold_en = 1'b1;
        hold_d  = {bus_i[BYTE_W-1], hold_q[WORD_W-1:1]};
      end else if (ptr_q < PTR_FULL) begin
        hold_en = 1'b1;
        hold_d  = par_word;
        ptr_d   = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign hold_o = hold_q;

  p_ptr_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_FULL);

  p_full_ignores_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!serial_i && ptr_q == PTR_FULL && !upd_edge_i && !mrst_i) |=> $stable(hold_q));

  p_rewind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_edge_i || mrst_i) |=> (ptr_q == '0));

  p_mrst_keeps_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mrst_i |=> $stable(hold_q));
endmodule

// File: rtl/cwl_commit.sv
module cwl_commit
  import cwl_pkg::*;
#(
  parameter int WORD_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_edge_i,
  input  logic              mrst_i,
  input  logic [WORD_W-1:0] hold_i,
  output act_t              act_o,
  output logic              serial_o,
  output logic              err_o
);
  act_t  act_q, act_d;
  logic  act_en;
  mode_e mode_q, mode_d;
  logic  err_q, err_d;
  ctl_e  ctl;
  logic  reserved, enter_bit;

  assign ctl       = ctl_e'(hold_i[CTL_LSB +: 2]);
  assign enter_bit = (mode_q == MODE_BYTE) && (ctl == CTL_SERIAL);
  assign reserved  = (mode_q == MODE_BIT) ? (ctl != CTL_NORMAL)
                                          : (ctl == CTL_TEST_A || ctl == CTL_TEST_B);

  always_comb begin
    act_d  = act_q;
    act_en = 1'b0;
    mode_d = mode_q;
    err_d  = err_q;
    if (mrst_i) begin
      act_en = 1'b1;
      act_d  = '0;
      err_d  = 1'b0;
    end else if (upd_edge_i) begin
      if (reserved) begin
        err_d = 1'b1;
      end else if (enter_bit) begin
        mode_d = MODE_BIT;
      end else begin
        act_en = 1'b1;
        act_d  = unpack_word(hold_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (act_en) act_q <= act_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_BYTE;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  assign act_o    = act_q;
  assign serial_o = (mode_q == MODE_BIT);
  assign err_o    = err_q;

  p_reserved_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_edge_i && reserved && !mrst_i) |=> ($stable(act_q) && err_q));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !mrst_i) |=> err_q);

  p_bit_mode_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_BIT) |=> (mode_q == MODE_BIT));

  p_enter_keeps_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_edge_i && enter_bit && !mrst_i) |=> $stable(act_q));

  p_mrst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mrst_i |=> (act_q == '0 && !err_q));
endmodule

// File: rtl/cwl_loader.sv
module cwl_loader
  import cwl_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int NBYTES      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mrst_i,
  input  logic               wr_i,
  input  logic               upd_i,
  input  logic [BYTE_W-1:0]  bus_i,
  output logic [TUNE_W-1:0]  tune_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               pdown_o,
  output logic               serial_o,
  output logic               err_o
);
  localparam int WORD_W = NBYTES * BYTE_W;

  logic              rst_sn;
  logic              upd_q;
  logic              upd_edge;
  logic [WORD_W-1:0] hold;
  act_t              act;

  cwl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sn)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) upd_q <= 1'b0;
    else         upd_q <= upd_i;
  end

  assign upd_edge = upd_i & ~upd_q;

  cwl_assembler #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_asm (
    .clk        (clk),
    .rst_n      (rst_sn),
    .wr_i       (wr_i),
    .upd_edge_i (upd_edge),
    .mrst_i     (mrst_i),
    .serial_i   (serial_o),
    .bus_i      (bus_i),
    .hold_o     (hold)
  );

  cwl_commit #(.WORD_W(WORD_W)) u_cmt (
    .clk        (clk),
    .rst_n      (rst_sn),
    .upd_edge_i (upd_edge),
    .mrst_i     (mrst_i),
    .hold_i     (hold),
    .act_o      (act),
    .serial_o   (serial_o),
    .err_o      (err_o)
  );

  assign tune_o  = act.tune;
  assign phase_o = act.phase;
  assign pdown_o = act.pd;

  p_level_no_recommit_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (!(upd_i && !upd_q) && !mrst_i) |=> $stable({tune_o, phase_o, pdown_o}));
endmodule

// File: tb/cwl_loader_test.sv
module cwl_loader_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, mrst, wr, upd;
  logic [7:0]  bus;
  logic [31:0] tune;
  logic [4:0]  phase;
  logic        pdown, serial, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  cwl_loader uut (
    .clk(clk), .rst_n(rst_n), .mrst_i(mrst), .wr_i(wr), .upd_i(upd), .bus_i(bus),
    .tune_o(tune), .phase_o(phase), .pdown_o(pdown), .serial_o(serial), .err_o(err)
  );

  // reference model built from the requirements
  logic [39:0] m_hold;
  int          m_ptr;
  logic        m_ser, m_err, m_pd;
  logic [31:0] m_tune;
  logic [4:0]  m_ph;

  // scoreboard
  logic [31:0] q_tune[$];
  logic [4:0]  q_ph[$];
  logic        q_pd[$], q_ser[$], q_err[$];
  string       q_tag[$];
  event        chk_ev;
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;

  task automatic push(input string tag);
    q_tune.push_back(m_tune); q_ph.push_back(m_ph); q_pd.push_back(m_pd);
    q_ser.push_back(m_ser);   q_err.push_back(m_err); q_tag.push_back(tag);
    -> chk_ev;
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (q_tag.size() > 0) begin
        logic [31:0] et; logic [4:0] ep; logic epd, es, ee; string t;
        et = q_tune.pop_front(); ep = q_ph.pop_front(); epd = q_pd.pop_front();
        es = q_ser.pop_front();  ee = q_err.pop_front(); t = q_tag.pop_front();
        checks++;
        if (tune !== et || phase !== ep || pdown !== epd || serial !== es || err !== ee) begin
          fails++;
          $display("FAIL %s: got tune=%h ph=%h pd=%b ser=%b err=%b expected tune=%h ph=%h pd=%b ser=%b err=%b",
                   t, tune, phase, pdown, serial, err, et, ep, epd, es, ee);
        end
      end
    end
  end

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); bus = b; wr = 1'b1;
    @(negedge clk); wr = 1'b0; bus = 8'h00;
    if (m_ser) m_hold = {b[7], m_hold[39:1]};
    else if (m_ptr < 5) begin m_hold[39-8*m_ptr -: 8] = b; m_ptr++; end
  endtask

  task automatic model_commit();
    logic [1:0] c;
    c = m_hold[33:32];
    m_ptr = 0;
    if (!m_ser && c == 2'b11) m_ser = 1'b1;
    else if (c != 2'b00) m_err = 1'b1;
    else begin m_tune = m_hold[31:0]; m_pd = m_hold[34]; m_ph = m_hold[39:35]; end
  endtask

  task automatic upd_pulse(input string tag);
    @(negedge clk); upd = 1'b1;
    @(negedge clk); upd = 1'b0;
    model_commit(); push(tag);
  endtask

  task automatic do_mrst(input string tag);
    @(negedge clk); mrst = 1'b1;
    @(negedge clk); mrst = 1'b0;
    m_tune = '0; m_ph = '0; m_pd = 1'b0; m_err = 1'b0; m_ptr = 0;
    push(tag);
  endtask

  task automatic load5(input logic [7:0] b0, input logic [31:0] tw);
    wr_byte(b0); wr_byte(tw[31:24]); wr_byte(tw[23:16]); wr_byte(tw[15:8]); wr_byte(tw[7:0]);
  endtask

  task automatic ser_word(input logic [39:0] w);
    for (int i = 0; i < 40; i++) wr_byte({w[i], 7'h55});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mrst = 1'b0; wr = 1'b0; upd = 1'b0; bus = 8'h00;
    m_hold = '0; m_ptr = 0; m_ser = 0; m_err = 0; m_pd = 0; m_tune = '0; m_ph = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    push("R1 reset state");

    // R2: byte order, two patterns
    load5(8'hA8, 32'h12345678);  upd_pulse("R2 byte load A");
    load5(8'h5C, 32'hDEADBEEF);  upd_pulse("R2 byte load with power-down");

    // R3: extra writes after five are ignored
    load5(8'h90, 32'hCAFEF00D); wr_byte(8'hFF); wr_byte(8'h11);
    upd_pulse("R3 saturated pointer");

    // R4: partial load keeps unwritten bytes
    wr_byte(8'h08); wr_byte(8'hAA);
    upd_pulse("R4 partial commit");

    // R5: update rewinds pointer
    wr_byte(8'h14);
    upd_pulse("R5 rewind to first byte");

    // R10: only rising edge commits
    load5(8'h64, 32'h0BADC0DE);
    @(negedge clk); upd = 1'b1;
    @(negedge clk); model_commit(); push("R10 first edge commits");
    wr_byte(8'h30);
    push("R10 level high no recommit");
    @(negedge clk); upd = 1'b0;
    upd_pulse("R10 next edge commits");

    // R8: reserved codes in byte mode
    load5(8'hF9, 32'h55555555); upd_pulse("R8 byte code 01");
    wr_byte(8'hFA);             upd_pulse("R8 byte code 10");
    wr_byte(8'h2C);             upd_pulse("R8 flag sticky after good commit");

    // R9: master reset
    load5(8'h4C, 32'h89ABCDEF);
    do_mrst("R9 mrst clears active and flag");
    upd_pulse("R9 holding kept across mrst");
    wr_byte(8'h00); wr_byte(8'h77); wr_byte(8'h66);
    do_mrst("R9 mrst second");
    wr_byte(8'h24);
    upd_pulse("R9 mrst rewinds pointer");

    // R6: enter bit-stream mode
    wr_byte(8'h03);
    upd_pulse("R6 enter bit mode");

    // R7: bit-stream loads
    ser_word({5'b10011, 1'b1, 2'b00, 32'h0F1E2D3C}); upd_pulse("R7 bit stream A");
    for (int i = 0; i < 5; i++) wr_byte(8'h80);
    ser_word({5'b01101, 1'b0, 2'b00, 32'hA5C3_9617}); upd_pulse("R7 bit stream B after extra bits");

    // R8: reserved codes in bit mode
    ser_word({5'b11111, 1'b1, 2'b01, 32'hFFFF0000}); upd_pulse("R8 bit code 01");
    ser_word({5'b11111, 1'b1, 2'b10, 32'h0000FFFF}); upd_pulse("R8 bit code 10");
    ser_word({5'b00001, 1'b0, 2'b11, 32'h13579BDF}); upd_pulse("R8 bit code 11");

    // R9: mode survives master reset
    do_mrst("R9 mrst keeps bit mode");
    ser_word({5'b00110, 1'b0, 2'b00, 32'h2468ACE0}); upd_pulse("R9 bit load after mrst");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule